// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Register

This block holds the event status word of an SD card host controller and the enable word that decides which events raise an interrupt. Event sources elsewhere in the host pulse one input bit per event. Each pulse sets a sticky status bit, and the bit stays set until software writes a one to the same position. Writing zeros leaves bits untouched. Because of this, software can read the status word and write the same value back to acknowledge exactly the events it saw, without losing events that arrive after the read.

A few status positions are not sticky. The buffer read-ready flag, the buffer write-ready flag and the card clock running flag follow live level inputs. A two-bit write-CRC status code is captured next to the write-CRC error bit. The code value 2 means the card gave no CRC reply, and it is reported as a timeout. An error summary ORs the five error bits. A single interrupt output combines the enabled events. Three further enable bits drive a separate wake output from the card insertion, card removal and SDIO interrupt events.

All outputs are registered. They are computed from the next-state values, so the status word, the enable word, the interrupt and the wake line all change on the same clock edge as the input or write that caused the change.

Top module: `sdh_status_irq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: A one on `evt_i[n]` at a clock edge sets sticky status bit n on that edge, and the bit stays set after the input returns to zero. Sticky positions are 31 (insertion), 30 (removal), 29:28 (buffer empty), 27:26 (buffer full), 25 (underrun), 24 (overflow), 14 (SDIO interrupt), 13 (command response end), 12 (write done), 11 (read or transfer done), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout).
- R3: A status write (`wr_en_i`=1, `wr_sel_i`=0) clears each sticky bit where `wr_data_i` holds a one and leaves every other status bit unchanged. It does not change the enable word.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R5: Status bits 8, 7 and 6 show `clk_run_i`, `rd_rdy_i` and `wr_rdy_i` as sampled at the last edge. They are not sticky, and writes have no effect on them.
- R6: Status bits 23:15 and 4 always read zero, even when events arrive on those input positions.
- R7: `err_o` is one exactly when the status word ANDed with 0x2f is nonzero.
- R8: When `evt_i[2]` is one, `wcrc_code_i` is captured into status bits 10:9. Those bits return to zero when status bit 2 is cleared. Writes to bits 10:9 are ignored. `crc_timeout_o` is one exactly when status bit 2 is set and bits 10:9 hold 2.
- R9: An enable write (`wr_en_i`=1, `wr_sel_i`=1) loads enable bits 4:0 and 18:12 from `wr_data_i`. All other enable bits read zero. Writing zero forces `irq_o` and `wake_o` low on the next edge.
- R10: `irq_o` is the OR of these pairs: enable 0 with status 11, enable 1 with status 12, enable 2 with status 13, enable 3 with status 6, enable 4 with status 7, enable 12 with `dat0_i`, enable 13 with status 14, enable 14 with status 30, and enable 15 with status 31.
- R11: `wake_o` is the OR of these pairs: enable 16 with status 30, enable 17 with status 31, and enable 18 with status 14.
- R12: Writing back the status value just read clears every sticky bit that was set, unless a new event arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event pulses, one per status position |
| wcrc_code_i | input | 2 | Write-CRC status code, captured with `evt_i[2]` |
| rd_rdy_i | input | 1 | Live buffer read-ready level |
| wr_rdy_i | input | 1 | Live buffer write-ready level |
| clk_run_i | input | 1 | Live card clock running level |
| dat0_i | input | 1 | Live DAT0 level used as an interrupt source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 is status (write one to clear), 1 is enable |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word |
| int_en_o | output | 32 | Enable word |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |
| err_o | output | 1 | Error summary |
| crc_timeout_o | output | 1 | Write CRC reported as missing reply |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the sticky mask covering the listed positions, the 0x2f error mask and the enable mask covering bits 4:0 and 18:12. With these values every defined status position, every unused position and every enable pairing can be reached. Sparse random events and random writes to both targets reach set-versus-clear collisions, and they give both values of the CRC field at the same time as a cleared bit 2. Directed cases cover the write-back acknowledge and the all-zero enable write.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;
  localparam int ST_W = 32;

  // status positions
  localparam int B_INS      = 31;
  localparam int B_REM      = 30;
  localparam int B_SDIO     = 14;
  localparam int B_CMD_END  = 13;
  localparam int B_WR_DONE  = 12;
  localparam int B_RD_DONE  = 11;
  localparam int B_CODE_LO  = 9;
  localparam int B_CLK_RUN  = 8;
  localparam int B_RD_RDY   = 7;
  localparam int B_WR_RDY   = 6;
  localparam int B_WCRC     = 2;

  // enable positions
  localparam int E_RD_DONE  = 0;
  localparam int E_WR_DONE  = 1;
  localparam int E_CMD_END  = 2;
  localparam int E_BUF_WR   = 3;
  localparam int E_BUF_RD   = 4;
  localparam int E_DAT0     = 12;
  localparam int E_SDIO     = 13;
  localparam int E_REM      = 14;
  localparam int E_INS      = 15;
  localparam int E_WK_REM   = 16;
  localparam int E_WK_INS   = 17;
  localparam int E_WK_SDIO  = 18;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_NO_REPLY = 2'd2;

  localparam logic [ST_W-1:0] STICKY_DEF = 32'hFF00_782F;
  localparam logic [ST_W-1:0] ERR_DEF    = 32'h0000_002F;
  localparam logic [ST_W-1:0] EN_DEF     = 32'h0007_F01F;
  localparam logic [ST_W-1:0] WAKE_DEF   = 32'h0007_0000;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] STICKY_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set has priority over clear in the same cycle
  assign nxt_o = STICKY_MASK & (evt_i | (q & ~clr_i));

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  // R2
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & STICKY_MASK) != '0) |=>
      ((q & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

  // R3
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~evt_i & STICKY_MASK) != '0) |=>
      ((q & $past(clr_i & ~evt_i & STICKY_MASK)) == '0));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0 && clr_i == '0) |=> $stable(q));
endmodule

// File: rtl/sdh_crc_field.sv
module sdh_crc_field #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic          clr_i,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] nxt_o,
  output logic [CW-1:0] q_o
);
  logic [CW-1:0] q;

  always_comb begin
    if (cap_i)      nxt_o = code_i;
    else if (clr_i) nxt_o = '0;
    else            nxt_o = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  // R8
  code_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (q == $past(code_i)));
endmodule

// File: rtl/sdh_irq_combine.sv
module sdh_irq_combine #(
  parameter int W = 32,
  parameter logic [W-1:0] EN_MASK   = '1,
  parameter logic [W-1:0] WAKE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_al_i,
  input  logic [W-1:0] wk_al_i,
  output logic [W-1:0] en_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [W-1:0] en_q, en_nxt;
  logic         irq_q, wake_q;
  logic         irq_nxt, wake_nxt;

  assign en_nxt   = en_wr_i ? (wdata_i & EN_MASK) : en_q;
  assign irq_nxt  = |(src_al_i & en_nxt & EN_MASK & ~WAKE_MASK);
  assign wake_nxt = |(wk_al_i & en_nxt & WAKE_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      irq_q  <= irq_nxt;
      wake_q <= wake_nxt;
    end
  end

  assign en_o   = en_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr_i && (wdata_i & EN_MASK) == '0) |=> (!irq_q && !wake_q));

  // R11
  wake_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> ((en_q & WAKE_MASK) != '0));

  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((en_q & EN_MASK & ~WAKE_MASK) != '0));
endmodule

// File: rtl/sdh_status_irq.sv
module sdh_status_irq
  import sdh_stat_pkg::*;
#(
  parameter int W = ST_W,
  parameter logic [W-1:0] STICKY_MASK = STICKY_DEF,
  parameter logic [W-1:0] ERR_MASK    = ERR_DEF,
  parameter logic [W-1:0] EN_MASK     = EN_DEF,
  parameter logic [W-1:0] WAKE_MASK   = WAKE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      evt_i,
  input  logic [CODE_W-1:0] wcrc_code_i,
  input  logic              rd_rdy_i,
  input  logic              wr_rdy_i,
  input  logic              clk_run_i,
  input  logic              dat0_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      int_en_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              err_o,
  output logic              crc_timeout_o
);
  localparam int CODE_HI = B_CODE_LO + CODE_W - 1;

  logic [W-1:0]      clr;
  logic [W-1:0]      sticky_nxt, sticky_q;
  logic [CODE_W-1:0] code_nxt, code_q;
  logic [W-1:0]      status_nxt, status_q;
  logic [W-1:0]      src_al, wk_al;
  logic              err_q, crc_to_q;
  logic              st_wr, en_wr;

  assign st_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS);
  assign en_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ENABLE);
  assign clr   = st_wr ? wr_data_i : '0;

  sdh_sticky_bank #(.W(W), .STICKY_MASK(STICKY_MASK)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_i),
    .clr_i (clr),
    .nxt_o (sticky_nxt),
    .q_o   (sticky_q)
  );

  sdh_crc_field #(.CW(CODE_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (evt_i[B_WCRC]),
    .clr_i  (clr[B_WCRC]),
    .code_i (wcrc_code_i),
    .nxt_o  (code_nxt),
    .q_o    (code_q)
  );

  always_comb begin
    status_nxt                     = sticky_nxt;
    status_nxt[CODE_HI:B_CODE_LO]  = code_nxt;
    status_nxt[B_CLK_RUN]          = clk_run_i;
    status_nxt[B_RD_RDY]           = rd_rdy_i;
    status_nxt[B_WR_RDY]           = wr_rdy_i;
  end

  always_comb begin
    src_al            = '0;
    src_al[E_RD_DONE] = status_nxt[B_RD_DONE];
    src_al[E_WR_DONE] = status_nxt[B_WR_DONE];
    src_al[E_CMD_END] = status_nxt[B_CMD_END];
    src_al[E_BUF_WR]  = status_nxt[B_WR_RDY];
    src_al[E_BUF_RD]  = status_nxt[B_RD_RDY];
    src_al[E_DAT0]    = dat0_i;
    src_al[E_SDIO]    = status_nxt[B_SDIO];
    src_al[E_REM]     = status_nxt[B_REM];
    src_al[E_INS]     = status_nxt[B_INS];
    wk_al             = '0;
    wk_al[E_WK_REM]   = status_nxt[B_REM];
    wk_al[E_WK_INS]   = status_nxt[B_INS];
    wk_al[E_WK_SDIO]  = status_nxt[B_SDIO];
  end

  sdh_irq_combine #(.W(W), .EN_MASK(EN_MASK), .WAKE_MASK(WAKE_MASK)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .en_wr_i  (en_wr),
    .wdata_i  (wr_data_i),
    .src_al_i (src_al),
    .wk_al_i  (wk_al),
    .en_o     (int_en_o),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      err_q    <= 1'b0;
      crc_to_q <= 1'b0;
    end else begin
      status_q <= status_nxt;
      err_q    <= |(status_nxt & ERR_MASK);
      crc_to_q <= sticky_nxt[B_WCRC] && (code_nxt == CODE_NO_REPLY);
    end
  end

  assign status_o      = status_q;
  assign err_o         = err_q;
  assign crc_timeout_o = crc_to_q;

  // R5
  live_rd_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[B_RD_RDY] == $past(rd_rdy_i)));

  // R7
  err_sum_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ((status_q & ERR_MASK) != '0));

  // R8
  crc_to_chk: assert property (@(posedge clk) disable iff (rst)
    crc_to_q |-> (status_q[B_WCRC] && code_q == CODE_NO_REPLY));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i[B_INS] && st_wr && wr_data_i[B_INS]) |=> status_q[B_INS]);

  // R6
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & ~STICKY_MASK) == '0));
endmodule

// File: tb/tb_sdh_status_irq.sv
module tb_sdh_status_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt = '0;
  logic [1:0]  code_in = '0;
  logic        rd_rdy = 0, wr_rdy = 0, clk_run = 0, dat0 = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] status, int_en;
  logic        irq, wake, err, crc_to;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] M_STICKY = 32'hFF00_782F;
  localparam logic [31:0] M_EN     = 32'h0007_F01F;

  logic [31:0] m_st = '0;
  logic [1:0]  m_code = '0;
  logic [31:0] m_en = '0;
  logic [31:0] x_status, x_en;
  logic        x_irq, x_wake, x_err, x_crc;

  always #10 clk = ~clk;

  sdh_status_irq dut (
    .clk(clk), .rst(rst), .evt_i(evt), .wcrc_code_i(code_in),
    .rd_rdy_i(rd_rdy), .wr_rdy_i(wr_rdy), .clk_run_i(clk_run), .dat0_i(dat0),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .status_o(status), .int_en_o(int_en), .irq_o(irq), .wake_o(wake),
    .err_o(err), .crc_timeout_o(crc_to)
  );

  function automatic void model_step();
    logic [31:0] clr;
    clr = (wr_en && !wr_sel) ? wr_data : 32'h0;
    m_st = M_STICKY & (evt | (m_st & ~clr));
    if (evt[2]) m_code = code_in;
    else if (clr[2]) m_code = 2'd0;
    if (wr_en && wr_sel) m_en = wr_data & M_EN;
    x_status = m_st | {21'd0, m_code, clk_run, rd_rdy, wr_rdy, 6'd0};
    x_en = m_en;
    x_irq = (m_en[0] & x_status[11]) | (m_en[1] & x_status[12]) |
            (m_en[2] & x_status[13]) | (m_en[3] & x_status[6]) |
            (m_en[4] & x_status[7])  | (m_en[12] & dat0) |
            (m_en[13] & x_status[14]) | (m_en[14] & x_status[30]) |
            (m_en[15] & x_status[31]);
    x_wake = (m_en[16] & x_status[30]) | (m_en[17] & x_status[31]) |
             (m_en[18] & x_status[14]);
    x_err = |(x_status & 32'h2f);
    x_crc = x_status[2] && (m_code == 2'd2);
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag,   "status", status, x_status);
    chk("R9",  "int_en", int_en, x_en);
    chk("R10", "irq", {31'd0, irq}, {31'd0, x_irq});
    chk("R11", "wake", {31'd0, wake}, {31'd0, x_wake});
    chk("R7",  "err", {31'd0, err}, {31'd0, x_err});
    chk("R8",  "crc_timeout", {31'd0, crc_to}, {31'd0, x_crc});
  endtask

  // inputs are set at a falling edge; the rising edge captures them
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    evt = '0;
    wr_en = 1'b0;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with inputs active
    evt = 32'hFFFF_FFFF; rd_rdy = 1; clk_run = 1; dat0 = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    x_status = '0; x_en = '0; x_irq = 0; x_wake = 0; x_err = 0; x_crc = 0;
    compare("R1");
    evt = '0; rd_rdy = 0; clk_run = 0; dat0 = 0;
    rst = 1'b0;
    step("R1");

    // R2: insertion pulse sets and holds
    evt = 32'h8000_0000; step("R2");
    step("R2");
    // R3: writing zeros leaves bits alone; writing one clears
    evt = 32'h0000_3800; step("R2");
    wr(1'b0, 32'h0); step("R3");
    wr(1'b0, 32'h8000_0800); step("R3");
    // R4: set and clear together on bit 13
    evt = 32'h0000_2000; wr(1'b0, 32'h0000_2000); step("R4");
    // R5: live levels follow, writes ignored
    rd_rdy = 1; wr_rdy = 1; clk_run = 1; step("R5");
    wr(1'b0, 32'h0000_01C0); step("R5");
    rd_rdy = 0; clk_run = 0; step("R5");
    wr_rdy = 0;
    // R6: events on undefined positions read zero
    evt = 32'h00FF_8010; step("R6");
    // R7: each error bit alone
    for (int b = 0; b < 6; b++) begin
      wr(1'b0, 32'hFFFF_FFFF); step("R12");
      evt = 32'h1 << b; step("R7");
    end
    // R8: code capture, no-reply report, clear with bit 2
    evt = 32'h4; code_in = 2'd2; step("R8");
    wr(1'b0, 32'h0000_0600); step("R8");
    evt = 32'h4; code_in = 2'd1; step("R8");
    wr(1'b0, 32'h4); step("R8");
    // R9: enable layout and masking
    wr(1'b1, 32'hFFFF_FFFF); step("R9");
    evt = 32'hC000_7800; dat0 = 1; step("R10");
    wr(1'b1, 32'h0); step("R9");
    dat0 = 0;
    // R10: each interrupt enable alone
    for (int e = 0; e < 16; e++) begin
      wr(1'b1, 32'h1 << e); step("R10");
    end
    // R11: each wake enable alone
    for (int e = 16; e < 19; e++) begin
      wr(1'b1, 32'h1 << e); step("R11");
    end
    // R12: write back what was read
    evt = 32'hFFFF_FFFF; step("R2");
    wr(1'b0, status); step("R12");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      evt = $urandom() & $urandom() & $urandom();
      code_in = 2'($urandom());
      rd_rdy = 1'($urandom()); wr_rdy = 1'($urandom());
      clk_run = 1'($urandom()); dat0 = 1'($urandom());
      if (($urandom() & 3) == 0) begin
        wr_en = 1'b1;
        wr_sel = 1'($urandom());
        wr_data = (($urandom() & 1) != 0) ? status : $urandom();
      end
      step("R2");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule